// File: doc/BRIEF.md
# Saturating Monitor Mix Datapath

This block folds a scaled copy of the stereo capture samples into the stereo playback samples. It sits ahead of the playback volume stage. Every sample period a strobe presents four 16-bit two's-complement words: left and right capture, and left and right playback. Both capture words are scaled down by one shared 4-bit monitor code. Each code step is worth 6 dB and is done as an arithmetic right shift. The top code removes the capture contribution entirely. The scaled capture word is added to the playback word of the same channel. The sum clips at the 16-bit limits and never wraps. The result is registered and flagged with a one-cycle valid pulse.

The monitor code is held in a register that resets to the mute code, so no mixing occurs until a code has been loaded. Two force inputs switch the monitor path off regardless of the code: one for the converter offset calibration and one for analog loopback. A mono control routes the left capture and left playback words to both output channels. Because the mixed result feeds the playback volume stage, the monitored content is attenuated a second time downstream. The capture stream sent to the host is not routed through this block and is untouched by it.

Top module: `monitor_mix`

## Requirements
- R1: With an effective mix code of 0, each output equals its playback input plus its capture input, with no scaling.
- R2: With an effective mix code k from 1 to 14, the capture word is arithmetically shifted right by k (sign extended, rounding toward minus infinity) before it is added. For example, code 14 turns -32768 into -2 and 32767 into 1.
- R3: With mix code 15, each output equals its playback input exactly, whatever the capture input.
- R4: Left and right capture words are always scaled by the same single code.
- R5: The sum saturates to +32767 when it exceeds the positive limit and to -32768 when it falls below the negative limit; it never wraps.
- R6: While cal_i is 1 at the strobe, the capture contribution is removed, so the outputs equal the playback inputs, whatever the mix code.
- R7: While aloop_i is 1 at the strobe, the capture contribution is removed in the same way as in R6.
- R8: With stereo_i at 0 (mono), both outputs equal the left playback word plus the scaled left capture word; the right inputs are ignored.
- R9: After reset, mix_l_o and mix_r_o are 0, valid_o is 0, and the mix code register holds 15. A sample strobed in the first clock after reset release is therefore passed with no mixing, whatever mix_code_i shows.
- R10: mix_code_i is registered on every clock and takes effect from the next clock. Outputs update on the clock edge that samples strb_i. valid_o is high for exactly the one cycle after each strobe, and the outputs hold their values between strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strb_i | input | 1 | Sample strobe, one cycle per sample |
| cap_l_i | input | 16 | Left capture sample, two's complement |
| cap_r_i | input | 16 | Right capture sample, two's complement |
| play_l_i | input | 16 | Left playback sample, two's complement |
| play_r_i | input | 16 | Right playback sample, two's complement |
| mix_code_i | input | 4 | Monitor code: 6 dB per step, 15 mutes |
| stereo_i | input | 1 | 1 = stereo, 0 = mono (left feeds both) |
| cal_i | input | 1 | Calibration in progress; forces the mix off |
| aloop_i | input | 1 | Analog loopback active; forces the mix off |
| mix_l_o | output | 16 | Mixed left sample |
| mix_r_o | output | 16 | Mixed right sample |
| valid_o | output | 1 | One-cycle pulse marking new outputs |

## Verification
The hardest case to reach from the ports is the window right after reset release. In that window the code register still holds its reset value while mix_code_i already asks for full mixing. The bench holds code 0 on the input throughout reset, releases reset and strobes a sample on the very next clock, and expects pure playback. The saturation corners are reached by pairing near-full-scale capture and playback words of equal sign at code 0, including a pair that sums to exactly one past the positive limit. The large-shift rounding corner is reached with full-scale negative and positive capture words at code 14.

// File: rtl/mix_pkg.sv
package mix_pkg;
  localparam int SMP_W  = 16;
  localparam int CODE_W = 4;
  localparam int NUM_CH = 2;
  localparam logic [CODE_W-1:0] MUTE_CODE = {CODE_W{1'b1}};
  typedef logic signed [SMP_W-1:0] smp_t;
endpackage

// File: rtl/mix_route.sv
module mix_route #(
  parameter int DATA_W = mix_pkg::SMP_W,
  parameter int NUM_CH = mix_pkg::NUM_CH
) (
  input  logic                          stereo_i,
  input  logic [NUM_CH-1:0][DATA_W-1:0] cap_i,
  input  logic [NUM_CH-1:0][DATA_W-1:0] play_i,
  output logic [NUM_CH-1:0][DATA_W-1:0] cap_o,
  output logic [NUM_CH-1:0][DATA_W-1:0] play_o
);
  // channel 0 is left; in mono every channel takes the left words
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign cap_o[c]  = stereo_i ? cap_i[c]  : cap_i[0];
    assign play_o[c] = stereo_i ? play_i[c] : play_i[0];
  end
endmodule

// File: rtl/mix_atten.sv
module mix_atten #(
  parameter int DATA_W = mix_pkg::SMP_W,
  parameter int CODE_W = mix_pkg::CODE_W
) (
  input  logic signed [DATA_W-1:0] smp_i,
  input  logic        [CODE_W-1:0] code_i,
  output logic signed [DATA_W-1:0] att_o
);
  localparam logic [CODE_W-1:0] MUTE = {CODE_W{1'b1}};

  always_comb begin
    if (code_i == MUTE) att_o = '0;
    else                att_o = smp_i >>> code_i;
  end

  always_comb begin
    if (!smp_i[DATA_W-1]) begin
      // R2
      atten_pos_bound_chk: assert (!att_o[DATA_W-1] && (att_o <= smp_i));
    end else begin
      // R2
      atten_neg_bound_chk: assert ((att_o <= 0) && (att_o >= smp_i));
    end
  end
endmodule

// File: rtl/mix_sat_add.sv
module mix_sat_add #(
  parameter int DATA_W = mix_pkg::SMP_W
) (
  input  logic signed [DATA_W-1:0] a_i,
  input  logic signed [DATA_W-1:0] b_i,
  output logic signed [DATA_W-1:0] sum_o
);
  localparam logic [DATA_W-1:0] POS_MAX = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] NEG_MIN = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W:0] wide;
  assign wide = {a_i[DATA_W-1], a_i} + {b_i[DATA_W-1], b_i};

  always_comb begin
    if (wide[DATA_W] != wide[DATA_W-1])
      sum_o = wide[DATA_W] ? NEG_MIN : POS_MAX;
    else
      sum_o = wide[DATA_W-1:0];
  end

  always_comb begin
    if (!a_i[DATA_W-1] && !b_i[DATA_W-1]) begin
      // R5
      no_wrap_pos_chk: assert (!sum_o[DATA_W-1]);
    end
    if (a_i[DATA_W-1] && b_i[DATA_W-1]) begin
      // R5
      no_wrap_neg_chk: assert (sum_o[DATA_W-1]);
    end
  end
endmodule

// File: rtl/monitor_mix.sv
module monitor_mix
  import mix_pkg::*;
#(
  parameter int DATA_W = SMP_W,
  parameter int CODE_W = mix_pkg::CODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strb_i,
  input  logic [DATA_W-1:0] cap_l_i,
  input  logic [DATA_W-1:0] cap_r_i,
  input  logic [DATA_W-1:0] play_l_i,
  input  logic [DATA_W-1:0] play_r_i,
  input  logic [CODE_W-1:0] mix_code_i,
  input  logic              stereo_i,
  input  logic              cal_i,
  input  logic              aloop_i,
  output logic [DATA_W-1:0] mix_l_o,
  output logic [DATA_W-1:0] mix_r_o,
  output logic              valid_o
);
  localparam int NCH = NUM_CH;
  localparam logic [CODE_W-1:0] MUTE = {CODE_W{1'b1}};

  logic [CODE_W-1:0]               code_q;
  logic [CODE_W-1:0]               eff_code;
  logic [NCH-1:0][DATA_W-1:0]      cap_raw, play_raw, cap_sel, play_sel;
  logic [NCH-1:0][DATA_W-1:0]      att, sum;
  logic [NCH-1:0][DATA_W-1:0]      out_q;
  logic                            valid_q;

  // code register resets to mute so nothing mixes before it is loaded
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) code_q <= MUTE;
    else         code_q <= mix_code_i;
  end

  assign eff_code = (cal_i || aloop_i) ? MUTE : code_q;

  assign cap_raw  = {cap_r_i, cap_l_i};
  assign play_raw = {play_r_i, play_l_i};

  mix_route #(.DATA_W(DATA_W), .NUM_CH(NCH)) i_route (
    .stereo_i (stereo_i),
    .cap_i    (cap_raw),
    .play_i   (play_raw),
    .cap_o    (cap_sel),
    .play_o   (play_sel)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    mix_atten #(.DATA_W(DATA_W), .CODE_W(CODE_W)) i_atten (
      .smp_i  (cap_sel[c]),
      .code_i (eff_code),
      .att_o  (att[c])
    );
    mix_sat_add #(.DATA_W(DATA_W)) i_add (
      .a_i   (play_sel[c]),
      .b_i   (att[c]),
      .sum_o (sum[c])
    );
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     out_q[c] <= '0;
      else if (strb_i) out_q[c] <= sum[c];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= 1'b0;
    else         valid_q <= strb_i;
  end

  assign mix_l_o = out_q[0];
  assign mix_r_o = out_q[1];
  assign valid_o = valid_q;

  // R10
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strb_i |=> valid_o);
  // R10
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strb_i |=> !valid_o);
  // R10
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strb_i |=> ($stable(mix_l_o) && $stable(mix_r_o)));
  // R6, R7
  force_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strb_i && (cal_i || aloop_i)) |=> (mix_l_o == $past(play_l_i)));
  // R8
  mono_equal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strb_i && !stereo_i) |=> (mix_l_o == mix_r_o));
  // R3
  mute_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strb_i && stereo_i && code_q == MUTE) |=>
      (mix_l_o == $past(play_l_i) && mix_r_o == $past(play_r_i)));
endmodule

// File: tb/test_monitor_mix.sv
module test_monitor_mix;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              strb = 1'b0;
  logic [15:0]       cap_l = '0, cap_r = '0, play_l = '0, play_r = '0;
  logic [3:0]        code = 4'd0;
  logic              stereo = 1'b1, cal = 1'b0, aloop = 1'b0;
  logic [15:0]       mix_l, mix_r;
  logic              valid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  monitor_mix i_monitor_mix (
    .clk_i(clk), .rst_ni(rst_n), .strb_i(strb),
    .cap_l_i(cap_l), .cap_r_i(cap_r), .play_l_i(play_l), .play_r_i(play_r),
    .mix_code_i(code), .stereo_i(stereo), .cal_i(cal), .aloop_i(aloop),
    .mix_l_o(mix_l), .mix_r_o(mix_r), .valid_o(valid)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // load code, wait one clock, strobe one sample, check result next cycle
  task automatic sample(input string req, input int c, input int cl, input int cr,
                        input int pl, input int pr, input int el, input int er);
    @(negedge clk);
    code = 4'(c);
    @(negedge clk);
    cap_l = 16'(cl); cap_r = 16'(cr); play_l = 16'(pl); play_r = 16'(pr);
    strb = 1'b1;
    @(negedge clk);
    strb = 1'b0;
    chk({req, " valid"}, int'(valid), 1);
    chk({req, " left"},  int'($signed(mix_l)), el);
    chk({req, " right"}, int'($signed(mix_r)), er);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R9 reset valid", int'(valid), 0);
    chk("R9 reset left", int'($signed(mix_l)), 0);
    chk("R9 reset right", int'($signed(mix_r)), 0);
    // code input already 0; register must still be at mute
    rst_n = 1'b1;
    cap_l = 16'd1000; cap_r = 16'd1000; play_l = 16'd200; play_r = -16'sd300;
    strb = 1'b1;
    @(negedge clk);
    strb = 1'b0;
    chk("R9 first strobe left", int'($signed(mix_l)), 200);
    chk("R9 first strobe right", int'($signed(mix_r)), -300);
  endtask

  task automatic t_timing;
    sample("R10 strobe", 0, 5, 6, 1, 2, 6, 8);
    cap_l = 16'd7777; play_l = 16'd1111;
    @(negedge clk);
    chk("R10 pulse ends", int'(valid), 0);
    chk("R10 hold left", int'($signed(mix_l)), 6);
    chk("R10 hold right", int'($signed(mix_r)), 8);
  endtask

  task automatic t_codes;
    sample("R1 code0", 0, 1000, -3000, 200, 50, 1200, -2950);
    sample("R2 R4 code3", 3, 1000, -1001, 0, 10, 125, -116);
    sample("R2 code14", 14, -32768, 32767, 100, 100, 98, 101);
    sample("R3 code15", 15, 5000, -5000, 7, -7, 7, -7);
  endtask

  task automatic t_sat;
    sample("R5 clip", 0, 30000, -30000, 10000, -10000, 32767, -32768);
    sample("R5 edge", 0, 16384, -16384, 16384, -16385, 32767, -32768);
    sample("R5 exact", 0, 32767, -32768, 0, 0, 32767, -32768);
  endtask

  task automatic t_force;
    cal = 1'b1;
    sample("R6 cal", 0, 1234, 1234, 11, -22, 11, -22);
    cal = 1'b0;
    aloop = 1'b1;
    sample("R7 aloop", 0, 1234, -999, 33, 44, 33, 44);
    aloop = 1'b0;
    sample("R6 R7 release", 0, 1, 2, 33, 44, 34, 46);
  endtask

  task automatic t_mono;
    stereo = 1'b0;
    sample("R8 mono", 1, 400, 9999, 30, -500, 230, 230);
    stereo = 1'b1;
  endtask

  initial begin
    t_reset();
    t_timing();
    t_codes();
    t_sat();
    t_force();
    t_mono();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule